// File: doc/BRIEF.md
# I2C Slave with Double-Buffered Byte Path

This block is an I2C target device with a register port for a local processor. Two holding registers face the processor, one for bytes to transmit and one for bytes received. Separate shift circuits on the bus side move the bits on SDA and SCL. The bus side recognises START and STOP and compares the 7-bit calling address with a programmed own address. On a match it acknowledges, then either receives bytes from the master or sends bytes to it.

Bytes pass between the holding registers and the shift circuits only at fixed points of the bus protocol. Two flags follow the fill state: a transmit-empty flag and a receive-full flag. The processor controls both flags by writing the transmit register and by reading the receive register.

Back-pressure runs in both directions through SCL stretching:
- If the bus needs a byte to send and the transmit register is empty, the block holds SCL low until the processor writes one.
- If a received byte is complete and the receive register is still full, the block holds SCL low until the processor reads it.

The processor port needs no handshake. A write takes effect at the clock edge. Read data appears one cycle after the read is presented.

Top module: `i2c_slave_dbuf`

## Requirements
- R1: After reset, status reads 0x11 (transmit-empty set, receive-full clear, address-match clear, read/write bit 0, received-acknowledge 1). The transmit register reads 0xFF and neither SDA nor SCL is pulled low.
- R2: The register index selects what is accessed: 0 is control (bit 0 enable, bits 7:1 own address), 1 is status, 2 is transmit, 3 is receive. Read data is valid in the cycle after the read. Status bits are: bit 0 transmit-empty, bit 1 receive-full, bit 2 address-match, bit 3 read/write, bit 4 received-acknowledge.
- R3: After START, the first byte carries the 7-bit address in bits 7:1 and the direction in bit 0 (1 = master reads). When the address equals the own address, the block pulls SDA low for the 9th clock, sets address-match and stores the direction bit. Any other address gets no acknowledge and leaves address-match clear.
- R4: A processor write of the transmit register clears transmit-empty. Moving the held byte into the output shifter sets transmit-empty.
- R5: When a matched address has direction 1, the held transmit byte moves into the output shifter at the end of the acknowledge clock. It is then sent MSB first.
- R6: After a sent byte, the acknowledge level driven by the master is stored in received-acknowledge at the 9th clock rising edge. A 0 moves the next held byte into the shifter at the end of that clock.
- R7: A 1 (not-acknowledge) from the master ends transmission. No byte is moved, transmit-empty stays as it is, and SDA stays released until STOP or START.
- R8: In receive, after the 8th data bit the byte moves into the receive register and receive-full sets. The block then pulls SDA low for the 9th clock.
- R9: A processor read of the receive register clears receive-full.
- R10: If a byte must be moved and its holding register is not ready, SCL is held low until it is. This means the transmit register is empty, or the receive register is full. The processor write or read then releases SCL and the transfer completes.
- R11: With enable 0 the block moves no bytes, gives no acknowledge and releases both lines.
- R12: STOP returns the block to idle and clears address-match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register index |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one cycle after the read |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low (stretch) |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
The assertions assume a well-behaved master:
- It changes SDA only while SCL is low, except when it makes START and STOP.
- It keeps every SCL phase several clocks longer than the two-flop input latency.
- It waits for SCL to read high before timing its high phase, so it honours stretching.

The bench master model follows these rules by construction. It uses phases of eight clocks and polls the wired-AND SCL level after each release. It also NACKs the last byte it reads before it sends STOP. The processor tasks touch the register port only on falling clock edges, so no access coincides with bus-side sampling.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_TX, S_TACK, S_HTX, S_RX, S_HRX, S_RACK, S_WAIT
  } slv_state_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_TXD  = 2'd2;
  localparam logic [1:0] REG_RXD  = 2'd3;

  typedef struct packed {
    logic rxak;
    logic rw;
    logic amatch;
    logic rx_full;
    logic tx_empty;
  } slv_stat_t;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LEN = (STAGES < 2) ? 2 : STAGES;

  logic [LEN-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[LEN-2:0], scl_i};
      sda_pipe <= {sda_pipe[LEN-2:0], sda_i};
      scl_d    <= scl_pipe[LEN-1];
      sda_d    <= sda_pipe[LEN-1];
    end
  end

  assign scl_q     = scl_pipe[LEN-1];
  assign sda_s     = sda_pipe[LEN-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // SDA edge counts as a condition only if SCL was high before and after
  assign start_det = scl_q & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] own_addr,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          tx_full,
  input  logic [DW-1:0] tx_byte,
  output logic          tx_load,
  input  logic          rx_full,
  output logic          rx_push,
  output logic [DW-1:0] rx_byte,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          amatch,
  output logic          rw_bit,
  output logic          rxak
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  slv_state_e st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, txsh;
  logic quiet, need_tx, need_rx;

  assign quiet   = !start_det && !stop_det;
  assign need_tx = (st == S_AACK && scl_fall && rw_bit) ||
                   (st == S_TACK && scl_fall && !rxak) ||
                   (st == S_HTX);
  assign need_rx = (st == S_RX && scl_fall && cnt == LAST) || (st == S_HRX);
  assign tx_load = en && quiet && need_tx && tx_full;
  assign rx_push = en && quiet && need_rx && !rx_full;
  assign rx_byte = sh;

  // Line drive follows the state: acknowledge phases, or a 0 data bit
  assign sda_oe = (st == S_AACK) || (st == S_RACK) ||
                  (st == S_TX && !txsh[DW-1]);
  assign scl_oe = (st == S_HTX) || (st == S_HRX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      txsh   <= '1;
      amatch <= 1'b0;
      rw_bit <= 1'b0;
      rxak   <= 1'b1;
    end else if (!en || stop_det) begin
      st     <= S_IDLE;
      amatch <= 1'b0;
    end else if (start_det) begin
      st     <= S_ADDR;
      cnt    <= '0;
      amatch <= 1'b0;
    end else begin
      case (st)
        S_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST) begin
            cnt <= '0;
            if (sh[DW-1 -: AW] == own_addr) begin
              amatch <= 1'b1;
              rw_bit <= sh[0];
              st     <= S_AACK;
            end else begin
              st <= S_WAIT;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            st  <= rw_bit ? S_HTX : S_RX;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST) begin
              cnt <= '0;
              st  <= S_TACK;
            end else begin
              txsh <= {txsh[DW-2:0], 1'b1};
            end
          end
        end
        S_TACK: begin
          if (scl_rise) rxak <= sda_s;
          else if (scl_fall) st <= rxak ? S_WAIT : S_HTX;
        end
        S_RX: begin
          if (scl_rise) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST) begin
            cnt <= '0;
            st  <= rx_push ? S_RACK : S_HRX;
          end
        end
        S_HRX: begin
          if (rx_push) st <= S_RACK;
        end
        S_RACK: begin
          if (scl_fall) begin
            cnt <= '0;
            st  <= S_RX;
          end
        end
        default: ;
      endcase
      if (tx_load) begin
        txsh <= tx_byte;
        cnt  <= '0;
        st   <= S_TX;
      end
    end
  end

  assert_off_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe && !scl_oe));
  assert_no_move_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(tx_load || rx_push));
  assert_stop_clears_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !amatch);
  assert_ack_only_matched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AACK) |-> amatch);
  assert_tx_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HTX && !tx_full && en && quiet) |=> (st == S_HTX && scl_oe));
  assert_rx_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HRX && rx_full && en && quiet) |=> (st == S_HRX && scl_oe));
endmodule

// File: rtl/i2c_slv_regs.sv
module i2c_slv_regs
  import i2c_slv_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          en,
  output logic [AW-1:0] own_addr,
  output logic [DW-1:0] tx_byte,
  output logic          tx_full,
  input  logic          tx_load,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_push,
  output logic          rx_full,
  input  logic          amatch,
  input  logic          rw_bit,
  input  logic          rxak
);
  logic [DW-1:0] ctrl_q, tx_hold, rx_hold;
  logic tx_empty, wr_tx, rd_rx, wr_ctrl;
  slv_stat_t stat;

  assign wr_ctrl  = cpu_sel && cpu_wr && cpu_addr == REG_CTRL;
  assign wr_tx    = cpu_sel && cpu_wr && cpu_addr == REG_TXD;
  assign rd_rx    = cpu_sel && !cpu_wr && cpu_addr == REG_RXD;
  assign en       = ctrl_q[0];
  assign own_addr = ctrl_q[DW-1 -: AW];
  assign tx_byte  = tx_hold;
  assign tx_full  = !tx_empty;
  assign stat     = '{rxak: rxak, rw: rw_bit, amatch: amatch,
                      rx_full: rx_full, tx_empty: tx_empty};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      tx_hold   <= '1;
      tx_empty  <= 1'b1;
      rx_hold   <= '0;
      rx_full   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= cpu_wdata;
      // A processor write wins over a same-cycle move into the shifter
      if (wr_tx) begin
        tx_hold  <= cpu_wdata;
        tx_empty <= 1'b0;
      end else if (tx_load) begin
        tx_empty <= 1'b1;
      end
      if (rx_push) begin
        rx_hold <= rx_byte;
        rx_full <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
      if (cpu_sel && !cpu_wr) begin
        case (cpu_addr)
          REG_CTRL: cpu_rdata <= ctrl_q;
          REG_STAT: cpu_rdata <= DW'(stat);
          REG_TXD:  cpu_rdata <= tx_hold;
          default:  cpu_rdata <= rx_hold;
        endcase
      end
    end
  end

  assert_write_clears_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !tx_empty);
  assert_load_sets_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !wr_tx) |=> tx_empty);
  assert_load_needs_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> !tx_empty);
  assert_push_sets_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (rx_full && rx_hold == $past(rx_byte)));
  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  assert_read_clears_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_push) |=> !rx_full);
endmodule

// File: rtl/i2c_slave_dbuf.sv
module i2c_slave_dbuf #(
  parameter int DW          = 8,
  parameter int AW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic en, tx_full, tx_load, rx_full, rx_push, amatch, rw_bit, rxak;
  logic [AW-1:0] own_addr;
  logic [DW-1:0] tx_byte, rx_byte;

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slv_engine #(.DW(DW), .AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .own_addr(own_addr),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .tx_full(tx_full), .tx_byte(tx_byte), .tx_load(tx_load),
    .rx_full(rx_full), .rx_push(rx_push), .rx_byte(rx_byte),
    .sda_oe(sda_oe), .scl_oe(scl_oe),
    .amatch(amatch), .rw_bit(rw_bit), .rxak(rxak)
  );

  i2c_slv_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .en(en), .own_addr(own_addr), .tx_byte(tx_byte), .tx_full(tx_full),
    .tx_load(tx_load), .rx_byte(rx_byte), .rx_push(rx_push),
    .rx_full(rx_full), .amatch(amatch), .rw_bit(rw_bit), .rxak(rxak)
  );
endmodule

// File: tb/test_i2c_slave_dbuf.sv
module test_i2c_slave_dbuf;
  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  int checks = 0, errors = 0;
  bit done = 0;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_slave_dbuf i_i2c_slave_dbuf (
    .clk(clk), .rst_n(rst_n), .cpu_sel(sel), .cpu_wr(wr), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_rdata(rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); d = rdata; sel = 0;
  endtask

  task automatic bus_bit(input logic b, output logic s);
    m_sda = b; wait_n(H);
    m_scl = 1;
    while (!scl_line) @(negedge clk);
    wait_n(H);
    s = sda_line;
    m_scl = 0; wait_n(H);
  endtask

  task automatic bus_start();
    m_sda = 1; wait_n(H);
    m_scl = 1;
    while (!scl_line) @(negedge clk);
    wait_n(H);
    m_sda = 0; wait_n(H);
    m_scl = 0; wait_n(H);
  endtask

  task automatic bus_stop();
    m_sda = 0; wait_n(H);
    m_scl = 1;
    while (!scl_line) @(negedge clk);
    wait_n(H);
    m_sda = 1; wait_n(H);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
    bus_bit(1'b1, ack);
  endtask

  task automatic recv8(output logic [7:0] v);
    logic s;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      v = {v[6:0], s};
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v, d0, d1, d2;
    logic ack, s;
    wait_n(4); rst_n = 1; wait_n(2);

    // R1 reset state
    cpu_read(2'd1, d); chk("R1 status", d, 8'h11);
    cpu_read(2'd2, d); chk("R1 tx reg", d, 8'hFF);
    chk("R1 lines", {scl_oe, sda_oe}, 2'b00);

    // R2 control register
    cpu_write(2'd0, {OWN, 1'b1});
    cpu_read(2'd0, d); chk("R2 ctrl", d, {OWN, 1'b1});

    // R3 / R12 address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk("R3 addr ack", ack, (7'(a) == OWN) ? 1'b0 : 1'b1);
      cpu_read(2'd1, d);
      chk("R3 match/rw", d & 8'h0C, (7'(a) == OWN) ? 8'h04 : 8'h00);
      bus_stop();
      cpu_read(2'd1, d); chk("R12 stop clears match", d & 8'h04, 8'h00);
    end

    // R8 / R9 receive sweep
    bus_start();
    send_byte({OWN, 1'b0}, ack); chk("R3 rx addr ack", ack, 1'b0);
    for (int k = 0; k < 8; k++) begin
      v = 8'(k * 53 + 7);
      send_byte(v, ack); chk("R8 data ack", ack, 1'b0);
      cpu_read(2'd1, d); chk("R8 rx full", d & 8'h02, 8'h02);
      cpu_read(2'd3, d); chk("R8 rx data", d, v);
      cpu_read(2'd1, d); chk("R9 read clears full", d & 8'h02, 8'h00);
    end
    send_byte(8'h5C, ack); chk("R8 ack", ack, 1'b0);
    // R10 receive stall: register still full when the next byte ends
    fork
      send_byte(8'hC3, ack);
      begin
        wait_n(300);
        chk("R10 scl held rx", scl_oe, 1'b1);
        cpu_read(2'd3, d); chk("R10 first byte", d, 8'h5C);
      end
    join
    chk("R10 ack after release", ack, 1'b0);
    cpu_read(2'd3, d); chk("R10 second byte", d, 8'hC3);
    bus_stop();

    // R4..R7 transmit sweep
    for (int k = 0; k < 4; k++) begin
      d0 = 8'(k * 75 + 33); d1 = ~d0; d2 = d0 ^ 8'h5A;
      cpu_write(2'd2, d0);
      cpu_read(2'd1, d); chk("R4 write clears empty", d & 8'h01, 8'h00);
      bus_start();
      send_byte({OWN, 1'b1}, ack); chk("R3 read addr ack", ack, 1'b0);
      cpu_read(2'd1, d); chk("R4 load sets empty / rw", d & 8'h09, 8'h09);
      recv8(v); chk("R5 first byte", v, d0);
      cpu_write(2'd2, d1);
      bus_bit(1'b0, s);
      cpu_read(2'd1, d); chk("R6 rxak=0", d & 8'h11, 8'h01);
      recv8(v); chk("R6 next byte", v, d1);
      cpu_write(2'd2, d2);
      bus_bit(1'b1, s);
      cpu_read(2'd1, d); chk("R7 nack no load", d & 8'h11, 8'h10);
      recv8(v); chk("R7 sda released", v, 8'hFF);
      bus_stop();
    end

    // R10 transmit stall, using d2 still held
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    recv8(v); chk("R5 pending byte", v, d2);
    bus_bit(1'b0, s);
    fork
      recv8(v);
      begin
        wait_n(100);
        chk("R10 scl held tx", scl_oe, 1'b1);
        cpu_write(2'd2, 8'h96);
      end
    join
    chk("R10 byte after write", v, 8'h96);
    bus_bit(1'b1, s);
    bus_stop();

    // R11 disabled
    cpu_write(2'd2, 8'hA5);
    cpu_write(2'd0, {OWN, 1'b0});
    bus_start();
    send_byte({OWN, 1'b1}, ack); chk("R11 no ack read", ack, 1'b1);
    cpu_read(2'd1, d); chk("R11 no load/no match", d & 8'h05, 8'h00);
    bus_stop();
    bus_start();
    send_byte({OWN, 1'b0}, ack); chk("R11 no ack write", ack, 1'b1);
    chk("R11 lines free", {scl_oe, sda_oe}, 2'b00);
    bus_stop();
    cpu_write(2'd0, {OWN, 1'b1});
    bus_start();
    send_byte({OWN, 1'b1}, ack); chk("R11 re-enabled ack", ack, 1'b0);
    recv8(v); chk("R5 kept byte", v, 8'hA5);
    bus_bit(1'b1, s);
    bus_stop();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule